// File: doc/BRIEF.md
# Codec Clock and Power-Mode Controller

This block works out the operating mode of a voice codec from the activity it sees on the codec's clock and frame-sync pins. Two of those pins do two jobs. The receive-master-clock pin is a clock while it toggles and a power-down level while it is static. The receive-bit-clock pin is a bit clock while it toggles and a master-clock frequency selector while it is static. A set of activity detectors samples each pin against a free-running reference clock. Each detector gives a verdict of toggling, static-low or static-high, and the mode logic turns the verdicts into the chip-level mode signals.

The outputs are as follows. A power-up flag. A receive half-channel flag, for when the transmit frame sync is missing but the receive frame sync runs. A code naming the master clock that drives internal sequencing. A flag telling the receive side to borrow the transmit bit clock. The decoded master-clock frequency, which a static strap input refines when the select pin is static low. A detector holds its committed verdict until two consecutive windows agree on a new one, so start-up glitches and single bursts of edges do not upset the mode.

Top module: `codec_clk_mode_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, until every detector has committed a first verdict, `power_up`=0, `half_channel`=0, `seq_src`=0, `rx_uses_tx_bclk`=0 and `mclk_freq`=3.
- R2: A frame-sync pin is active when a rising edge falls in every frame window of `FS_WIN` reference cycles. A clock pin is toggling when an edge of either direction falls in every window of `CLK_WIN` cycles. A frame sync pulsing with period `FS_WIN`-2 counts as active.
- R3: When the power-down pin is static high, `power_up`=0 whatever the frame syncs do.
- R4: When the power-down pin is static low or toggling, `power_up`=1 if at least one frame sync is active, and 0 if neither is.
- R5: When powered up with the transmit frame sync active, `seq_src`=1 (transmit master clock) and `half_channel`=0, whatever the power-down pin is doing.
- R6: When powered up with the transmit frame sync absent and the receive frame sync active, `half_channel`=1. In that case `seq_src`=2 (receive master clock) if the power-down pin toggles, and 0 if it is static.
- R7: `rx_uses_tx_bclk`=1 when the receive bit-clock pin is static at either level, and 0 when it toggles; while it toggles, `mclk_freq`=3 (not decoded).
- R8: With the receive bit-clock pin static high, `mclk_freq`=2 (2.048 MHz). With it static low, `mclk_freq`=0 (1.536 MHz) when `freq_strap`=0 and `mclk_freq`=1 (1.544 MHz) when `freq_strap`=1.
- R9: A new verdict is committed only at the end of a window, and only after two consecutive windows agree on it. A single rising edge on an otherwise quiet frame sync leaves every output unchanged.
- R10: While `power_up`=0, `seq_src`=0 and `half_channel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock used for all sampling |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_fsync_pin | input | 1 | Transmit frame sync, asynchronous |
| rx_fsync_pin | input | 1 | Receive frame sync, asynchronous |
| rx_mclk_pd_pin | input | 1 | Receive master clock or power-down level |
| rx_bclk_sel_pin | input | 1 | Receive bit clock or frequency-select level |
| freq_strap | input | 1 | Static strap: 0 selects 1.536 MHz, 1 selects 1.544 MHz (used when the select pin is static low) |
| power_up | output | 1 | 1 when the codec is powered up |
| half_channel | output | 1 | 1 in receive half-channel mode |
| seq_src | output | 2 | Sequencing source: 0 none, 1 transmit master clock, 2 receive master clock |
| rx_uses_tx_bclk | output | 1 | 1 when the receive side uses the transmit bit clock |
| mclk_freq | output | 2 | 0 1.536 MHz, 1 1.544 MHz, 2 2.048 MHz, 3 not decoded |

## Verification
The frame windows and the clock windows run independently. A commit from a frame-sync detector can therefore land in the same cycle as a commit from the power-down detector, or one cycle away from it. The bench provokes this by changing a frame sync and the power-down pin in the same scenario step, for example stopping the transmit sync while the power-down pin goes high or starts clocking. It then checks that no cycle shows half-channel mode or a sequencing source while power is down, and that the settled outputs match the mode computed from the new pin patterns.

// File: rtl/cmc_pkg.sv
// Shared types for the codec clock/power-mode controller.
// Assumes: used by every module of the block; no state lives here.
package cmc_pkg;

    // Source of the internal sequencing clocks.
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_TX_MCLK = 2'd1,
        SRC_RX_MCLK = 2'd2
    } seq_src_e;

    // Assumed master-clock frequency.
    typedef enum logic [1:0] {
        FREQ_1M536   = 2'd0,
        FREQ_1M544   = 2'd1,
        FREQ_2M048   = 2'd2,
        FREQ_UNKNOWN = 2'd3
    } mclk_freq_e;

    // Verdict of one activity window: toggling, or static at a level.
    typedef struct packed {
        logic toggling;
        logic level;
    } pin_verdict_t;

endpackage

// File: rtl/cmc_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pin levels.
// Assumes: each bit is independent (no bus coherency needed); STAGES >= 2.
module cmc_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pin levels into the first flop row.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                // Pass the levels one row further to settle metastability.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cmc_activity_det.sv
// Activity detector for one synchronized pin.
// A window of WINDOW reference cycles ends with a verdict: toggling if an
// edge was seen (rising only when RISE_ONLY), otherwise static at the
// level sampled at window end. A verdict is committed only when two
// consecutive windows agree; update_o pulses the cycle the committed value
// first shows. Assumes: pin_s is already synchronized; WINDOW >= 2.
module cmc_activity_det
    import cmc_pkg::*;
#(
    parameter int WINDOW    = 64,
    parameter bit RISE_ONLY = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin_s,
    output pin_verdict_t verdict_o,
    output logic         valid_o,
    output logic         update_o
);

    localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

    logic [CW-1:0] cnt_q;
    logic          prev_q;
    logic          seen_q;
    logic          edge_now;
    logic          win_end;
    pin_verdict_t  sample;
    pin_verdict_t  cand_q;
    logic          cand_ok_q;
    pin_verdict_t  commit_q;
    logic          valid_q;
    logic          commit;
    logic          update_q;

    // Pick the kind of edge that counts as activity for this pin.
    generate
        if (RISE_ONLY) begin : g_rise
            assign edge_now = pin_s & ~prev_q;
        end else begin : g_any
            assign edge_now = pin_s ^ prev_q;
        end
    endgenerate

    assign win_end = (cnt_q == LAST);

    // Verdict for the window closing this cycle, edges of this cycle included.
    always_comb begin
        sample.toggling = seen_q | edge_now;
        sample.level    = sample.toggling ? 1'b0 : pin_s;
    end

    // Commit when the closing window matches the previous one and differs.
    assign commit = win_end && cand_ok_q && (sample == cand_q)
                    && (!valid_q || (sample != commit_q));

    // Free-running window counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (win_end) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    // Track the previous level and collect edges within the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= pin_s;
            seen_q <= win_end ? 1'b0 : (seen_q | edge_now);
        end
    end

    // Remember the last window's verdict as the candidate for agreement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q    <= '0;
            cand_ok_q <= 1'b0;
        end else if (win_end) begin
            cand_q    <= sample;
            cand_ok_q <= 1'b1;
        end
    end

    // Hold the committed verdict and flag each update for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_q <= '0;
            valid_q  <= 1'b0;
            update_q <= 1'b0;
        end else begin
            update_q <= commit;
            if (commit) begin
                commit_q <= sample;
                valid_q  <= 1'b1;
            end
        end
    end

    assign verdict_o = commit_q;
    assign valid_o   = valid_q;
    assign update_o  = update_q;

    AST_VERDICT_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(commit_q) |-> $past(win_end)); // R9

    AST_VALID_NEEDS_WINDOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_q) |-> $past(cand_ok_q)); // R9

endmodule

// File: rtl/cmc_mode_decide.sv
// Mode decision: turns the committed pin verdicts into the registered mode
// outputs. Outputs keep their reset values until every detector is valid.
// Assumes: verdicts change only on detector update pulses; strap is synced.
module cmc_mode_decide
    import cmc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  pin_verdict_t tx_fs_v,
    input  pin_verdict_t rx_fs_v,
    input  pin_verdict_t pd_v,
    input  pin_verdict_t bclk_v,
    input  logic [3:0]   valid_i,
    input  logic         any_update_i,
    input  logic         strap_s,
    output logic         power_up_o,
    output logic         half_channel_o,
    output seq_src_e     seq_src_o,
    output logic         rx_uses_tx_bclk_o,
    output mclk_freq_e   mclk_freq_o
);

    logic       all_valid;
    logic       pd_allows;
    logic       pu_n;
    logic       half_n;
    seq_src_e   src_n;
    logic       shared_n;
    mclk_freq_e freq_n;

    assign all_valid = &valid_i;

    // Combinational mode equations from the committed verdicts.
    always_comb begin
        pd_allows = pd_v.toggling | ~pd_v.level;
        pu_n      = pd_allows & (tx_fs_v.toggling | rx_fs_v.toggling);
        half_n    = pu_n & ~tx_fs_v.toggling & rx_fs_v.toggling;
        if (!pu_n)                 src_n = SRC_NONE;
        else if (tx_fs_v.toggling) src_n = SRC_TX_MCLK;
        else if (pd_v.toggling)    src_n = SRC_RX_MCLK;
        else                       src_n = SRC_NONE;
        shared_n = ~bclk_v.toggling;
        if (bclk_v.toggling)   freq_n = FREQ_UNKNOWN;
        else if (bclk_v.level) freq_n = FREQ_2M048;
        else if (strap_s)      freq_n = FREQ_1M544;
        else                   freq_n = FREQ_1M536;
    end

    // Register the mode outputs once all detectors have a verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            power_up_o        <= 1'b0;
            half_channel_o    <= 1'b0;
            seq_src_o         <= SRC_NONE;
            rx_uses_tx_bclk_o <= 1'b0;
            mclk_freq_o       <= FREQ_UNKNOWN;
        end else if (all_valid) begin
            power_up_o        <= pu_n;
            half_channel_o    <= half_n;
            seq_src_o         <= src_n;
            rx_uses_tx_bclk_o <= shared_n;
            mclk_freq_o       <= freq_n;
        end
    end

    AST_HALF_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        half_channel_o |-> power_up_o); // R6

    AST_RX_SRC_ONLY_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_src_o == SRC_RX_MCLK) |-> half_channel_o); // R6

    AST_SRC_OFF_WHEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !power_up_o |-> (seq_src_o == SRC_NONE)); // R10

    AST_POWER_FOLLOWS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(power_up_o) |-> $past(any_update_i)); // R9

endmodule

// File: rtl/codec_clk_mode_ctrl.sv
// Top level: synchronizes the codec pins, runs one activity detector per
// pin (frame syncs on a frame-length window with rising edges, clock pins on
// a short window with any edge) and decides the operating mode.
// Assumes: FS_WIN covers more than one frame in reference cycles and
// CLK_WIN covers several periods of the slowest clock on a clock pin.
module codec_clk_mode_ctrl #(
    parameter int CLK_WIN     = 64,
    parameter int FS_WIN      = 3072,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_fsync_pin,
    input  logic       rx_fsync_pin,
    input  logic       rx_mclk_pd_pin,
    input  logic       rx_bclk_sel_pin,
    input  logic       freq_strap,
    output logic       power_up,
    output logic       half_channel,
    output logic [1:0] seq_src,
    output logic       rx_uses_tx_bclk,
    output logic [1:0] mclk_freq
);
    import cmc_pkg::*;

    localparam int NPIN = 4;   // 0 tx fsync, 1 rx fsync, 2 power-down, 3 bit-clock select
    localparam int NSYN = NPIN + 1;

    logic [NSYN-1:0]  raw;
    logic [NSYN-1:0]  synced;
    pin_verdict_t     verdict [NPIN];
    logic [NPIN-1:0]  valid;
    logic [NPIN-1:0]  update;
    seq_src_e         src_e;
    mclk_freq_e       freq_e;

    assign raw = {freq_strap, rx_bclk_sel_pin, rx_mclk_pd_pin, rx_fsync_pin, tx_fsync_pin};

    cmc_sync #(
        .WIDTH  (NSYN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw),
        .sync_o  (synced)
    );

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_det
            cmc_activity_det #(
                .WINDOW    ((p < 2) ? FS_WIN : CLK_WIN),
                .RISE_ONLY ((p < 2) ? 1'b1 : 1'b0)
            ) u_det (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_s     (synced[p]),
                .verdict_o (verdict[p]),
                .valid_o   (valid[p]),
                .update_o  (update[p])
            );
        end
    endgenerate

    cmc_mode_decide u_decide (
        .clk               (clk),
        .rst_n             (rst_n),
        .tx_fs_v           (verdict[0]),
        .rx_fs_v           (verdict[1]),
        .pd_v              (verdict[2]),
        .bclk_v            (verdict[3]),
        .valid_i           (valid),
        .any_update_i      (|update),
        .strap_s           (synced[NPIN]),
        .power_up_o        (power_up),
        .half_channel_o    (half_channel),
        .seq_src_o         (src_e),
        .rx_uses_tx_bclk_o (rx_uses_tx_bclk),
        .mclk_freq_o       (freq_e)
    );

    assign seq_src   = src_e;
    assign mclk_freq = freq_e;

endmodule

// File: tb/codec_clk_mode_ctrl_tb.sv
`timescale 1ns/1ps
module codec_clk_mode_ctrl_tb;

    localparam int CLK_WIN = 16;
    localparam int FS_WIN  = 64;
    localparam int SETTLE  = 4 * FS_WIN + 12;
    localparam int WD_CYC  = 150000;

    // Pin modes
    localparam int M_LOW = 0, M_HIGH = 1, M_TOG = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_fs = 1'b0, rx_fs = 1'b0, pd = 1'b0, bclk = 1'b0, strap = 1'b0;
    logic power_up, half_channel, rx_uses_tx_bclk;
    logic [1:0] seq_src, mclk_freq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int tx_mode = M_LOW, rx_mode = M_LOW, pd_mode = M_LOW, bc_mode = M_LOW;
    int tx_per = 40, rx_per = 40, pd_half = 3, bc_half = 2;

    always #5 clk = ~clk;

    codec_clk_mode_ctrl #(
        .CLK_WIN     (CLK_WIN),
        .FS_WIN      (FS_WIN),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .tx_fsync_pin    (tx_fs),
        .rx_fsync_pin    (rx_fs),
        .rx_mclk_pd_pin  (pd),
        .rx_bclk_sel_pin (bclk),
        .freq_strap      (strap),
        .power_up        (power_up),
        .half_channel    (half_channel),
        .seq_src         (seq_src),
        .rx_uses_tx_bclk (rx_uses_tx_bclk),
        .mclk_freq       (mclk_freq)
    );

    // Pin pattern generator, driven on the falling edge.
    initial begin
        int ctx = 0, crx = 0, cpd = 0, cbc = 0;
        forever begin
            @(negedge clk);
            if (tx_mode == M_TOG) begin ctx = (ctx + 1) % tx_per; tx_fs = (ctx < 2); end
            else tx_fs = (tx_mode == M_HIGH);
            if (rx_mode == M_TOG) begin crx = (crx + 1) % rx_per; rx_fs = (crx < 3); end
            else rx_fs = (rx_mode == M_HIGH);
            if (pd_mode == M_TOG) begin cpd++; if (cpd >= pd_half) begin pd = ~pd; cpd = 0; end end
            else pd = (pd_mode == M_HIGH);
            if (bc_mode == M_TOG) begin cbc++; if (cbc >= bc_half) begin bclk = ~bclk; cbc = 0; end end
            else bclk = (bc_mode == M_HIGH);
        end
    end

    // Expected output vector {pu, half, src[1:0], shared, freq[1:0]} from the requirements.
    function automatic logic [6:0] expect_out(int txm, int rxm, int pdm, int bcm, logic st);
        logic pu, half, shared;
        logic [1:0] src, freq;
        pu   = (pdm != M_HIGH) && (txm == M_TOG || rxm == M_TOG);
        half = pu && (txm != M_TOG) && (rxm == M_TOG);
        if (!pu)                src = 2'd0;
        else if (txm == M_TOG)  src = 2'd1;
        else if (pdm == M_TOG)  src = 2'd2;
        else                    src = 2'd0;
        shared = (bcm != M_TOG);
        if (bcm == M_TOG)       freq = 2'd3;
        else if (bcm == M_HIGH) freq = 2'd2;
        else                    freq = st ? 2'd1 : 2'd0;
        return {pu, half, src, shared, freq};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Compare all outputs with the expected mode.
    task automatic check_mode(string note);
        logic [6:0] e;
        e = expect_out(tx_mode, rx_mode, pd_mode, bc_mode, strap);
        chk((pd_mode == M_HIGH) ? "R3" : "R4", {note, " power_up"}, int'(power_up), int'(e[6]));
        chk(e[6] ? "R6" : "R10", {note, " half_channel"}, int'(half_channel), int'(e[5]));
        chk(!e[6] ? "R10" : (tx_mode == M_TOG) ? "R5" : "R6", {note, " seq_src"}, int'(seq_src), int'(e[4:3]));
        chk("R7", {note, " rx_uses_tx_bclk"}, int'(rx_uses_tx_bclk), int'(e[2]));
        chk("R8", {note, " mclk_freq"}, int'(mclk_freq), int'(e[1:0]));
    endtask

    // Apply a pattern, let it settle, sample between edges.
    task automatic run_case(int txm, int rxm, int pdm, int bcm, logic st, string note);
        bit bad_half;
        @(posedge clk); #1;
        tx_mode = txm; rx_mode = rxm; pd_mode = pdm; bc_mode = bcm; strap = st;
        bad_half = 1'b0;
        for (int i = 0; i < SETTLE; i++) begin
            @(negedge clk);
            if ((half_channel || seq_src != 2'd0) && !power_up) bad_half = 1'b1;
        end
        chk("R10", {note, " no half/src while down"}, int'(bad_half), 0);
        check_mode(note);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset values
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset power_up", int'(power_up), 0);
        chk("R1", "reset mclk_freq", int'(mclk_freq), 3);
        rst_n = 1'b1;
        repeat (FS_WIN / 2) @(posedge clk);
        @(negedge clk);
        chk("R1", "pre-verdict seq_src", int'(seq_src), 0);
        chk("R1", "pre-verdict rx_uses_tx_bclk", int'(rx_uses_tx_bclk), 0);

        // Directed corners
        run_case(M_TOG, M_LOW,  M_LOW,  M_LOW,  1'b0, "tx only");
        run_case(M_LOW, M_TOG,  M_TOG,  M_HIGH, 1'b0, "rx half, pd clocking");
        run_case(M_LOW, M_TOG,  M_LOW,  M_LOW,  1'b1, "rx half, pd low");
        run_case(M_TOG, M_TOG,  M_HIGH, M_TOG,  1'b0, "pd high with syncs");
        run_case(M_TOG, M_TOG,  M_TOG,  M_LOW,  1'b1, "both syncs, pd clocking");
        run_case(M_LOW, M_LOW,  M_LOW,  M_HIGH, 1'b0, "no syncs");

        // R2 boundary: frame period just under the frame window
        tx_per = FS_WIN - 2;
        run_case(M_TOG, M_LOW, M_LOW, M_LOW, 1'b0, "R2 period FS_WIN-2");
        chk("R2", "slow sync active", int'(power_up), 1);
        tx_per = 40;

        // R9: a single rising edge on a quiet frame sync changes nothing
        run_case(M_LOW, M_LOW, M_LOW, M_LOW, 1'b0, "quiet");
        begin
            bit moved;
            moved = 1'b0;
            @(negedge clk); rx_mode = M_HIGH;
            repeat (2) @(negedge clk);
            rx_mode = M_LOW;
            for (int i = 0; i < SETTLE; i++) begin
                @(negedge clk);
                if (power_up || half_channel || seq_src != 2'd0) moved = 1'b1;
            end
            chk("R9", "single edge ignored", int'(moved), 0);
        end

        // Constrained random scenarios
        for (int n = 0; n < 30; n++) begin
            tx_per  = 20 + int'($urandom_range(0, 30));
            rx_per  = 20 + int'($urandom_range(0, 30));
            pd_half = 1 + int'($urandom_range(0, 5));
            bc_half = 1 + int'($urandom_range(0, 5));
            run_case(int'($urandom_range(0, 2)), int'($urandom_range(0, 2)),
                     int'($urandom_range(0, 2)), int'($urandom_range(0, 2)),
                     logic'($urandom_range(0, 1)), "random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule